// File: doc/BRIEF.md
# Fractional audio clock divider

This block turns a fast parent clock into a slower audio clock whose average period need not be a whole number of parent cycles. One 32-bit control word sets the ratio. The ratio is built from three fields: an integer part counted in pairs of parent cycles, a single half-step bit, and an 8-bit fraction over a denominator of 255. A running accumulator adds the fraction once per output period. When the accumulator passes 255, that period gets one extra parent cycle, so the long-run average matches the programmed ratio.

Software writes the control word through a plain write port and can read it back unchanged. One bit of the word is an inverted enable: while it is set, the output is held low and the internal counters are cleared. The block drives two outputs. `divClk` is a near-50% duty clock. `clkEn` is a one-cycle strobe at the start of every output period, for logic that stays in the parent clock domain.

Top module: `audio_frac_div`

## Requirements
- R1: A synchronous active-low reset sets the control word to 32'h0200_0000 (stop bit 25 set, all else zero), with `divClk` and `clkEn` low.
- R2: `rdData` returns exactly the last word written, all 32 bits, from the cycle after the write.
- R3: With FRAC in bits 7:0, INT in bits 23:16 and SEL in bit 24, each period lasts 2*INT+SEL parent cycles. The accumulator starts at 0 and adds FRAC at each period start, modulo 255. The period is one cycle longer whenever that addition reaches or passes 255.
- R4: When INT is 0, every period lasts exactly 2 parent cycles, whatever SEL and FRAC hold.
- R5: While bit 25 is set, `divClk` and `clkEn` are low from the cycle after the write that set it, and the period state is cleared.
- R6: After a write that clears bit 25, the first `clkEn` comes one cycle after the write takes effect, with the accumulator at 0.
- R7: `divClk` is high for the first floor(N/2) cycles of an N-cycle period and low for the rest.
- R8: A write while running does not change the length of the current period. The new setting applies from the next period start.
- R9: Bit 28, bits 15:8 and the other unused bits are stored but do not affect the output.
- R10: `clkEn` is high for exactly one cycle per period, in the first cycle of the period, together with `divClk` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word to store |
| rdData | output | 32 | Stored control word |
| clkEn | output | 1 | One-cycle strobe at the start of each output period |
| divClk | output | 1 | Divided clock, high for the first half of each period |

## Verification
The bench builds the block with its default 8-bit integer and 8-bit fraction fields. With these values, the modulo-255 wrap patterns are visible within three periods: no wrap, every period wrapping, and alternating wraps. The INT-of-zero clamp and the half-step bit are reached with short settings. The longest period the fields allow, 512 cycles, is not stepped through. Mid-period rewrites and stop/restart sequences are timed against the period-start strobe.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int REG_W    = 32;
  localparam int INT_W    = 8;
  localparam int FRAC_W   = 8;
  localparam int FRAC_LSB = 0;
  localparam int INT_LSB  = 16;
  localparam int SEL_BIT  = 24;
  localparam int STOP_BIT = 25;
  localparam int LEN_W    = INT_W + 2;
  localparam int DEN      = (1 << FRAC_W) - 1;
  localparam int MIN_LEN  = 2;
  localparam logic [REG_W-1:0] RST_VAL = REG_W'(1) << STOP_BIT;

  typedef struct packed {
    logic             stop;
    logic             load;
    logic [LEN_W-1:0] nextLen;
  } divStrb_t;
endpackage

// File: rtl/afd_ctrl.sv
module afd_ctrl
  import afd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             lastCycle,
  output logic [REG_W-1:0] cfgReg,
  output divStrb_t         strb
);
  logic [REG_W-1:0]  regQ;
  logic [FRAC_W-1:0] accQ;
  logic [FRAC_W-1:0] accNext;
  logic [FRAC_W:0]   accSum;
  logic [INT_W-1:0]  intField;
  logic [FRAC_W-1:0] fracField;
  logic              selField;
  logic              accWrap;
  logic              intZero;
  logic [LEN_W-1:0]  baseLen;

  assign intField  = regQ[INT_LSB +: INT_W];
  assign fracField = regQ[FRAC_LSB +: FRAC_W];
  assign selField  = regQ[SEL_BIT];
  assign intZero   = (intField == '0);

  // accumulator step, modulo the fixed denominator
  always_comb begin
    accSum  = {1'b0, accQ} + {1'b0, fracField};
    accWrap = (accSum >= (FRAC_W+1)'(DEN));
    if (accWrap) accNext = FRAC_W'(accSum - (FRAC_W+1)'(DEN));
    else         accNext = accSum[FRAC_W-1:0];
  end

  assign baseLen = {1'b0, intField, selField};

  always_comb begin
    strb.stop = regQ[STOP_BIT];
    strb.load = !regQ[STOP_BIT] && lastCycle;
    if (intZero) strb.nextLen = LEN_W'(MIN_LEN);
    else         strb.nextLen = baseLen + LEN_W'(accWrap);
  end

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= RST_VAL;
    else if (wrEn) regQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.stop) accQ <= '0;
    else if (strb.load && !intZero) accQ <= accNext;
  end

  assign cfgReg = regQ;

  // R1
  reset_val_chk: assert property (@(posedge clk) !rstN |=> regQ == RST_VAL);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regQ == $past(wrData));
  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    accQ < FRAC_W'(DEN));
  // R5
  acc_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stop |=> accQ == '0);
endmodule

// File: rtl/afd_datapath.sv
module afd_datapath
  import afd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  divStrb_t strb,
  output logic     lastCycle,
  output logic     clkEn,
  output logic     divClk
);
  logic             runQ;
  logic [LEN_W-1:0] posQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] halfLen;

  assign halfLen   = lenQ >> 1;
  assign lastCycle = !runQ || (posQ == lenQ - LEN_W'(1));
  assign divClk    = runQ && !strb.stop && (posQ < halfLen);
  assign clkEn     = runQ && !strb.stop && (posQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      posQ <= '0;
      lenQ <= LEN_W'(MIN_LEN);
    end else if (strb.stop) begin
      runQ <= 1'b0;
      posQ <= '0;
    end else if (strb.load) begin
      runQ <= 1'b1;
      posQ <= '0;
      lenQ <= strb.nextLen;
    end else if (runQ) begin
      posQ <= posQ + LEN_W'(1);
    end
  end

  // R4
  len_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> lenQ >= LEN_W'(MIN_LEN));
  // R8
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ && !strb.load && !strb.stop |=> $stable(lenQ));
  // R10
  pulse_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> divClk);
  // R5
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stop |=> !runQ && posQ == '0);
endmodule

// File: rtl/audio_frac_div.sv
module audio_frac_div
  import afd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             clkEn,
  output logic             divClk
);
  divStrb_t strb;
  logic     lastCycle;

  afd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .lastCycle (lastCycle),
    .cfgReg    (rdData),
    .strb      (strb)
  );

  afd_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lastCycle (lastCycle),
    .clkEn     (clkEn),
    .divClk    (divClk)
  );
endmodule

// File: tb/audio_frac_div_bench.sv
`timescale 1ns/1ps
module audio_frac_div_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        clkEn;
  logic        divClk;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  audio_frac_div u_audio_frac_div (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .clkEn(clkEn), .divClk(divClk)
  );

  localparam int NVEC = 10;
  localparam logic [31:0] VEC_CFG [0:NVEC-1] = '{
    32'h1002FF00, 32'h1103FF00, 32'h0002FF80, 32'h1101FFFF, 32'h1100FFC8,
    32'h00000000, 32'h1005FF55, 32'h0001FFAA, 32'h0002FF00, 32'h00021200};
  localparam int VEC_LEN [0:NVEC-1][0:2] = '{
    '{4,4,4}, '{7,7,7}, '{4,5,4}, '{4,4,4}, '{2,2,2},
    '{2,2,2}, '{10,10,11}, '{2,3,3}, '{4,4,4}, '{4,4,4}};
  localparam string VEC_REQ [0:NVEC-1] = '{
    "R3", "R3", "R3", "R3", "R4", "R4", "R3", "R3", "R9", "R9"};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  task automatic writeReg(input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses [0:7];
    int np;
    int highs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdData == 32'h0200_0000, "R1", rdData, 32'h0200_0000);
    chk(!divClk && !clkEn, "R1", {divClk, clkEn}, 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      writeReg(VEC_CFG[v] | 32'h0200_0000);
      chk(rdData == (VEC_CFG[v] | 32'h0200_0000), "R2", rdData, VEC_CFG[v] | 32'h0200_0000);
      writeReg(VEC_CFG[v]);
      chk(rdData == VEC_CFG[v], "R2", rdData, VEC_CFG[v]);
      np = 0;
      highs = 0;
      for (int c = 1; c <= 60; c++) begin
        @(negedge clk);
        if (clkEn) begin
          if (np < 8) pulses[np] = c;
          np++;
          // R10 strobe in first, high, cycle
          chk(divClk == 1'b1, "R10", divClk, 1);
        end
        if (np == 1 && divClk) highs++;
      end
      chk(np >= 4, "R10", np, 4);
      if (np >= 4) begin
        // R6 fresh start one cycle after the enabling write
        chk(pulses[0] == 1, "R6", pulses[0], 1);
        for (int k = 0; k < 3; k++)
          chk(pulses[k+1] - pulses[k] == VEC_LEN[v][k], VEC_REQ[v],
              pulses[k+1] - pulses[k], VEC_LEN[v][k]);
        // R7 high phase of the first period
        chk(highs == VEC_LEN[v][0] / 2, "R7", highs, VEC_LEN[v][0] / 2);
      end
    end

    // R5 stop while running
    writeReg(32'h0202FF00);
    chk(!divClk && !clkEn, "R5", {divClk, clkEn}, 0);
    highs = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (divClk || clkEn) highs++;
    end
    chk(highs == 0, "R5", highs, 0);

    // R8 rewrite in the middle of a period
    writeReg(32'h0004FF00);
    np = 0;
    for (int c = 1; c <= 30; c++) begin
      @(negedge clk);
      if (clkEn) begin
        if (np < 8) pulses[np] = c;
        np++;
      end
      if (c == 3) begin
        wrEn = 1'b1;
        wrData = 32'h0002FF00;
      end else if (c == 4) begin
        wrEn = 1'b0;
      end
    end
    chk(np >= 3, "R8", np, 3);
    if (np >= 3) begin
      chk(pulses[1] - pulses[0] == 8, "R8", pulses[1] - pulses[0], 8);
      chk(pulses[2] - pulses[1] == 4, "R8", pulses[2] - pulses[1], 4);
    end

    // R1 reset while running
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(rdData == 32'h0200_0000, "R1", rdData, 32'h0200_0000);
    rstN = 1'b1;
    @(negedge clk);
    chk(!divClk && !clkEn, "R1", {divClk, clkEn}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule